// File: doc/BRIEF.md
# PCM Serial Voice Port

This block connects a voice codec's serial PCM lines to a sample-processing core. The codec supplies a bit clock, a one-bit-period frame sync and a serial input line. The port runs entirely in the system clock domain. It brings these three signals in through two-flop synchronisers and finds the bit-clock edges there. Each frame carries one 16-bit word in each direction. The received word is assembled most significant bit first and handed to the core with a one-cycle receive strobe. The word to send is taken from the core when the frame starts, and a one-cycle transmit strobe asks the core for the next word.

A frame starts on the falling bit-clock edge at which the frame sync is high (the frame marker). The next sixteen falling edges sample the input bits. The rising edges that follow the marker launch the output bits, so the codec can sample each one on the next falling edge. A bypass control connects the serial input pin straight to the serial output pin, stops both strobes and drops the core enable.

The controller has three states. In `ST_IDLE` it waits for a marker. In `ST_ACTIVE` a frame is in progress. `ST_BYPASS` is the wire-through mode. The transitions are: *start* (`ST_IDLE` to `ST_ACTIVE` on a marker), *resync* (`ST_ACTIVE` to `ST_ACTIVE` on a marker inside a frame), *complete* (`ST_ACTIVE` to `ST_IDLE` on the sixteenth data bit), *enter* (any state to `ST_BYPASS` while bypass is requested) and *leave* (`ST_BYPASS` to `ST_IDLE` when the request drops).

Top module: `pcm_voice_port`

## Requirements
- R1: After reset, `sdout_o`, `rx_strobe_o` and `tx_load_o` are 0, `rx_word_o` is 0 and `core_en_o` is 1.
- R2: The first falling edge after the marker samples bit 15 of the received word, and each later falling edge samples the next lower bit, down to bit 0.
- R3: `rx_strobe_o` is high for exactly one system cycle, 3 system clock rising edges after the sixteenth data falling edge arrives at the pin. `rx_word_o` takes the new word in that same cycle and holds its value at all other times.
- R4: When a marker is detected, `tx_load_o` pulses for one cycle, 3 rising system edges after the marker's falling edge. `tx_word_i` is captured in that same cycle.
- R5: After a marker, the next sixteen rising bit-clock edges each put one bit of the captured word on `sdout_o`, bit 15 first, and each bit holds until the following falling edge. Any rising edge outside a frame drives `sdout_o` to 0.
- R6: A marker inside a frame restarts the frame. The partial word produces no receive strobe, the transmit word is reloaded, and the sixteen bits after the new marker form the received word.
- R7: Outside a frame, falling edges without the frame sync are ignored: no strobe is raised and `rx_word_o` keeps its value.
- R8: One cycle after `bypass_i` rises, `core_en_o` is 0 and `sdout_o` follows `sdin_i` with no clock delay. While in bypass, no strobe is raised and `rx_word_o` holds its value.
- R9: After `bypass_i` falls, the port returns to idle and waits for a fresh marker before it captures data.
- R10: A marker on the falling edge right after a frame's sixteenth bit starts the next frame without losing a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Codec bit clock, asynchronous to `clk` |
| fsync_i | input | 1 | Frame sync, high across one falling bit-clock edge |
| sdin_i | input | 1 | Serial data from the codec |
| sdout_o | output | 1 | Serial data to the codec |
| bypass_i | input | 1 | Request to wire `sdin_i` straight to `sdout_o` |
| tx_word_i | input | 16 | Word the core supplies for the next outgoing frame |
| tx_load_o | output | 1 | Transmit strobe: `tx_word_i` was taken |
| rx_word_o | output | 16 | Last complete received word |
| rx_strobe_o | output | 1 | Receive strobe: a new `rx_word_o` is present |
| core_en_o | output | 1 | High while the processing core may run |

## Verification
Any pin change reaches the edge detector after two synchronising flops, and the action it triggers is registered on the third rising system edge. Both strobes and a newly launched output bit are therefore due 3 rising edges after the bench drives the bit-clock edge. The bench holds each half bit period for 4 system cycles and drives every pin on a falling system edge. Its behavioural model puts the expected strobe cycles in queues, and on every clock it compares both strobes and `rx_word_o` against them. It reads `sdout_o` one cycle before each falling edge that it drives, after the launched bit is due. Bypass equality is read 1 time unit after `sdin_i` changes, and `core_en_o` one cycle after the request.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_BYPASS = 2'd2
    } port_state_t;

    localparam int unsigned SAMPLE_W_DEF = 16;
    localparam int unsigned SYNC_DEPTH_DEF = 2;

endpackage

// File: rtl/pcm_edge_sync.sv
module pcm_edge_sync #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic fsync_in,
    input  logic data_in,
    output logic fall_evt,
    output logic rise_evt,
    output logic fsync_s,
    output logic data_s
);
    localparam int unsigned NSIG = 3;

    logic [NSIG-1:0] stage [DEPTH];
    logic            bclk_hist;

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= '0;
                    else        stage[g] <= {bclk_in, fsync_in, data_in};
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= '0;
                    else        stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bclk_hist <= 1'b0;
        else        bclk_hist <= stage[DEPTH-1][2];
    end

    assign fall_evt = bclk_hist & ~stage[DEPTH-1][2];
    assign rise_evt = ~bclk_hist & stage[DEPTH-1][2];
    assign fsync_s  = stage[DEPTH-1][1];
    assign data_s   = stage[DEPTH-1][0];

endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             shift,
    input  logic             din,
    output logic             done,
    output logic [WIDTH-1:0] word_o,
    output logic             strobe_o
);
    localparam int unsigned CW = $clog2(WIDTH);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    logic [WIDTH-1:0] shreg;
    logic [CW-1:0]    cnt;

    assign done = shift && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (shift) begin
            shreg <= {shreg[WIDTH-2:0], din};
            cnt   <= done ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_o   <= '0;
            strobe_o <= 1'b0;
        end else begin
            strobe_o <= done;
            if (done) word_o <= {shreg[WIDTH-2:0], din};
        end
    end

endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_word,
    input  logic             launch,
    input  logic             active,
    output logic             bit_o,
    output logic             load_pulse_o
);
    logic [WIDTH-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            bit_o <= 1'b0;
        end else if (load) begin
            shreg <= load_word;
        end else if (launch) begin
            if (active) begin
                bit_o <= shreg[WIDTH-1];
                shreg <= {shreg[WIDTH-2:0], 1'b0};
            end else begin
                bit_o <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) load_pulse_o <= 1'b0;
        else        load_pulse_o <= load;
    end

endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
    import pcm_port_pkg::*;
#(
    parameter int unsigned SAMPLE_W   = SAMPLE_W_DEF,
    parameter int unsigned SYNC_DEPTH = SYNC_DEPTH_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                fsync_i,
    input  logic                sdin_i,
    output logic                sdout_o,
    input  logic                bypass_i,
    input  logic [SAMPLE_W-1:0] tx_word_i,
    output logic                tx_load_o,
    output logic [SAMPLE_W-1:0] rx_word_o,
    output logic                rx_strobe_o,
    output logic                core_en_o
);
    port_state_t state_q, state_d;

    logic fall_evt, rise_evt, fsync_s, data_s;
    logic mark, shift, rx_done, in_frame, tx_bit;

    pcm_edge_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .bclk_in  (bclk_i),
        .fsync_in (fsync_i),
        .data_in  (sdin_i),
        .fall_evt (fall_evt),
        .rise_evt (rise_evt),
        .fsync_s  (fsync_s),
        .data_s   (data_s)
    );

    assign mark     = fall_evt & fsync_s & (state_q != ST_BYPASS);
    assign in_frame = (state_q == ST_ACTIVE);
    assign shift    = fall_evt & ~fsync_s & in_frame;

    pcm_rx_deser #(.WIDTH(SAMPLE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (mark),
        .shift    (shift),
        .din      (data_s),
        .done     (rx_done),
        .word_o   (rx_word_o),
        .strobe_o (rx_strobe_o)
    );

    pcm_tx_ser #(.WIDTH(SAMPLE_W)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (mark),
        .load_word    (tx_word_i),
        .launch       (rise_evt),
        .active       (in_frame),
        .bit_o        (tx_bit),
        .load_pulse_o (tx_load_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start, resync, complete, enter, leave
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bypass_i)  state_d = ST_BYPASS;
                else if (mark) state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (bypass_i)     state_d = ST_BYPASS;
                else if (mark)    state_d = ST_ACTIVE;
                else if (rx_done) state_d = ST_IDLE;
            end
            ST_BYPASS: begin
                if (!bypass_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        core_en_o = 1'b1;
        sdout_o   = tx_bit;
        unique case (state_q)
            ST_IDLE, ST_ACTIVE: begin
                core_en_o = 1'b1;
                sdout_o   = tx_bit;
            end
            ST_BYPASS: begin
                core_en_o = 1'b0;
                sdout_o   = sdin_i;
            end
            default: begin
                core_en_o = 1'b1;
                sdout_o   = tx_bit;
            end
        endcase
    end

endmodule

// File: rtl/pcm_voice_port_chk.sv
module pcm_voice_port_chk #(
    parameter int unsigned SAMPLE_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sdin_i,
    input logic                sdout_o,
    input logic                bypass_i,
    input logic                tx_load_o,
    input logic [SAMPLE_W-1:0] rx_word_o,
    input logic                rx_strobe_o,
    input logic                core_en_o
);
    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe_o |=> !rx_strobe_o); // R3

    AST_RX_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_strobe_o |-> $stable(rx_word_o)); // R3

    AST_TX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load_o |=> !tx_load_o); // R4

    AST_BYPASS_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        bypass_i |=> !core_en_o); // R8

    AST_BYPASS_WIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en_o |-> (sdout_o == sdin_i)); // R8

    AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en_o |-> (!rx_strobe_o && !tx_load_o)); // R8

endmodule

bind pcm_voice_port pcm_voice_port_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sdin_i      (sdin_i),
    .sdout_o     (sdout_o),
    .bypass_i    (bypass_i),
    .tx_load_o   (tx_load_o),
    .rx_word_o   (rx_word_o),
    .rx_strobe_o (rx_strobe_o),
    .core_en_o   (core_en_o)
);

// File: tb/pcm_voice_port_test.sv
`timescale 1ns/1ps
module pcm_voice_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_i = 1'b0, fsync_i = 1'b0, sdin_i = 1'b0, bypass_i = 1'b0;
    logic [15:0] tx_word_i = 16'h0000;
    logic        sdout_o, tx_load_o, rx_strobe_o, core_en_o;
    logic [15:0] rx_word_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done_run = 0;

    // behavioural model state
    int          exp_rx_q[$];
    int          exp_tx_q[$];
    logic [15:0] exp_word_q[$];
    logic [15:0] last_word = 16'h0000;
    bit          act_m = 0, byp_m = 0;
    int          cnt_m = 0;
    logic [15:0] rx_m = 0, tx_sh_m = 0;
    bit          tx_exp_bit = 0;

    pcm_voice_port uut (
        .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .fsync_i(fsync_i),
        .sdin_i(sdin_i), .sdout_o(sdout_o), .bypass_i(bypass_i),
        .tx_word_i(tx_word_i), .tx_load_o(tx_load_o), .rx_word_o(rx_word_o),
        .rx_strobe_o(rx_strobe_o), .core_en_o(core_en_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // every-clock comparison against the model's schedule
    always @(negedge clk) begin
        if (rst_n && !done_run) begin
            bit er, et;
            er = (exp_rx_q.size() > 0) && (exp_rx_q[0] == cyc);
            et = (exp_tx_q.size() > 0) && (exp_tx_q[0] == cyc);
            if (er) begin
                void'(exp_rx_q.pop_front());
                last_word = exp_word_q.pop_front();
            end
            if (et) void'(exp_tx_q.pop_front());
            chk(rx_strobe_o == er, "R3 rx strobe timing", rx_strobe_o, er);
            chk(rx_word_o == last_word, "R2 rx word", rx_word_o, last_word);
            chk(tx_load_o == et, "R4 tx load timing", tx_load_o, et);
        end
    end

    // one bit period: rise then fall, 4 system cycles each half
    task automatic bitp(input bit fs, input bit d);
        @(negedge clk);
        bclk_i = 1'b1; fsync_i = fs; sdin_i = d;
        if (!byp_m) begin
            if (act_m) begin
                tx_exp_bit = tx_sh_m[15];
                tx_sh_m = tx_sh_m << 1;
            end else begin
                tx_exp_bit = 1'b0;
            end
        end
        repeat (3) @(negedge clk);
        if (byp_m) chk(sdout_o == sdin_i, "R8 bypass wire", sdout_o, sdin_i);
        else       chk(sdout_o == tx_exp_bit, "R5 tx bit", sdout_o, tx_exp_bit);
        @(negedge clk);
        bclk_i = 1'b0;
        if (!byp_m) begin
            if (fs) begin
                exp_tx_q.push_back(cyc + 3);
                tx_sh_m = tx_word_i;
                act_m = 1; cnt_m = 0;
            end else if (act_m) begin
                rx_m = {rx_m[14:0], d};
                cnt_m++;
                if (cnt_m == 16) begin
                    exp_rx_q.push_back(cyc + 3);
                    exp_word_q.push_back(rx_m);
                    act_m = 0;
                end
            end
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic frame(input logic [15:0] w);
        bitp(1'b1, 1'b0);
        for (int i = 15; i >= 0; i--) bitp(1'b0, w[i]);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done_run) begin
            done_run = 1;
            checks++; errors++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sdout_o == 0, "R1 sdout", sdout_o, 0);
        chk(rx_strobe_o == 0 && tx_load_o == 0, "R1 strobes", {rx_strobe_o, tx_load_o}, 0);
        chk(rx_word_o == 0, "R1 rx word", rx_word_o, 0);
        chk(core_en_o == 1, "R1 core enable", core_en_o, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R7 idle bits without marker are ignored
        for (int i = 0; i < 5; i++) bitp(1'b0, 1'b1);

        // R2 R4 R5 basic frames, then R10 back-to-back
        tx_word_i = 16'hA5C3;
        frame(16'h1234);
        tx_word_i = 16'h8001;
        frame(16'hFFFF);
        tx_word_i = 16'h7FFE;
        frame(16'h0000);
        tx_word_i = 16'h0F0F;
        frame(16'hC001);

        // R6 marker inside a frame restarts it
        tx_word_i = 16'h3C3C;
        bitp(1'b1, 1'b0);
        for (int i = 0; i < 7; i++) bitp(1'b0, i[0]);
        tx_word_i = 16'hE7E7;
        frame(16'h5AA5);
        bitp(1'b0, 1'b0);

        // R8 bypass
        @(negedge clk);
        bypass_i = 1'b1; byp_m = 1; act_m = 0;
        @(negedge clk);
        chk(core_en_o == 0, "R8 core enable low", core_en_o, 0);
        sdin_i = 1'b1; #1;
        chk(sdout_o == 1, "R8 wire high", sdout_o, 1);
        @(negedge clk);
        sdin_i = 1'b0; #1;
        chk(sdout_o == 0, "R8 wire low", sdout_o, 0);
        frame(16'h9999);

        // R9 leave bypass: stray bits ignored until marker
        @(negedge clk);
        bypass_i = 1'b0; byp_m = 0; act_m = 0;
        repeat (2) @(negedge clk);
        chk(core_en_o == 1, "R9 core enable back", core_en_o, 1);
        for (int i = 0; i < 6; i++) bitp(1'b0, 1'b1);
        tx_word_i = 16'h1357;
        frame(16'h2468);
        bitp(1'b0, 1'b0);
        repeat (8) @(negedge clk);
        chk(exp_rx_q.size() == 0, "R3 all rx strobes seen", exp_rx_q.size(), 0);
        chk(exp_tx_q.size() == 0, "R4 all tx loads seen", exp_tx_q.size(), 0);

        done_run = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule